// File: doc/BRIEF.md
# Carry-Save Accumulating Booth Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the product into a running 40-bit total, one product per clock. The multiplier operand is recoded into radix-4 Booth digits. Negative digits select the bit-inverted multiplicand, and a separate correction bit in each row completes the negation. Sign extension of the rows is replaced by an inverted top bit and one constant row. All rows go into a carry-save compressor together with the fed-back accumulator state. No full-width carry-propagate adder sits in the accumulation loop.

The accumulator is held in redundant form. It is made of an upper sum vector, an upper carry vector, a block of low-order bits already resolved by a narrow adder after the compressor, and the single carry out of that narrow adder. A full result is formed only when one is requested. A short adder combines the upper vectors and the carry, and its output is concatenated with the stored low bits. The result is registered and flagged valid on the following cycle. A synchronous clear empties the accumulator. If a product arrives in the same cycle as the clear, it becomes the new total.

Top module: `booth_csa_mac`

## Requirements
- R1: After any sequence of accepted operand pairs (acc_en high), a requested result equals the sum of the signed products of those pairs as a 40-bit two's-complement value.
- R2: res_valid is high in exactly the cycle after a cycle with rd_req high, and low otherwise.
- R3: The reported result is the total as it stood before the request cycle. An accumulate or clear in that same cycle takes effect only for later requests.
- R4: A cycle with clr high and acc_en low leaves the total at zero. A cycle with both high leaves the total equal to that cycle's product alone.
- R5: A cycle with acc_en and clr both low leaves the total unchanged.
- R6: The operand extremes are handled exactly, including -32768 × -32768 = 1073741824 and -32768 × 32767.
- R7: The total wraps modulo 2^40. For example, 1024 products of 2^30 each bring the total back to 0.
- R8: After reset, res_valid is low, res is zero and the total is zero.
- R9: res keeps its value in every cycle in which res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Add op_a × op_b into the total this cycle |
| clr | input | 1 | Empty the total this cycle |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier (Booth-recoded) |
| rd_req | input | 1 | Request the current total |
| res_valid | output | 1 | res holds a requested total |
| res | output | 40 | Signed accumulated total |

## Verification
Several properties are checked on every cycle by the assertions. They cover the one-cycle relation between a request and its valid flag, res holding steady between requests, the accumulator state holding on idle cycles, and the state being all zero after a clear with no product. The arithmetic itself can only be shown by the bench scenarios, which compare each requested total with an independent sum of signed products. This covers the Booth recoding, the one's-complement correction, the sign constant and the split between low and upper bits. The scenarios also cover the extreme operands, mixed signs, the wrap at 2^40, and requests or clears that coincide with a new product.

// File: rtl/booth_mac_pkg.sv
// Package: shared Booth digit selection type and its decoder.
// Assumes radix-4 recoding on overlapping bit triplets of the multiplier.
package booth_mac_pkg;

    typedef struct packed {
        logic neg;  // digit is negative: invert multiplicand, add correction bit
        logic one;  // magnitude one
        logic two;  // magnitude two
    } booth_sel_t;

    // Decode one multiplier triplet {upper, middle, lower} into a digit selection.
    function automatic booth_sel_t booth_decode(input logic [2:0] trip);
        booth_sel_t d;
        d.one = trip[1] ^ trip[0];
        d.two = (trip == 3'b011) || (trip == 3'b100);
        d.neg = trip[2] && !(trip[1] && trip[0]);
        return d;
    endfunction

endpackage

// File: rtl/booth_row_gen.sv
// Booth row generator: produces one partial-product row per radix-4 digit of
// op_b. Negative digits use the one's complement of the multiplicand, and the
// +1 correction bits are gathered in a separate vector. The top bit of each
// row is inverted so that no sign extension is needed. The matching constant
// row is added by the parent.
// Assumes OP_W is even and ACC_W >= 2*OP_W.
module booth_row_gen #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    localparam int NROWS = OP_W / 2
) (
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] rows [NROWS],
    output logic [ACC_W-1:0] corr
);
    import booth_mac_pkg::*;

    localparam int PP_W = OP_W + 1;

    logic [OP_W:0] b_ext;
    assign b_ext = {op_b, 1'b0};

    logic [NROWS-1:0] neg_bits;

    for (genvar i = 0; i < NROWS; i++) begin : g_row
        booth_sel_t      sel;
        logic [PP_W-1:0] mag;
        logic [PP_W-1:0] pat;

        // Select the digit magnitude, invert it for a negative digit, flip its sign bit.
        always_comb begin
            sel = booth_decode(b_ext[2*i+2 -: 3]);
            if (sel.two)
                mag = {op_a, 1'b0};
            else if (sel.one)
                mag = {op_a[OP_W-1], op_a};
            else
                mag = '0;
            pat = sel.neg ? ~mag : mag;
            pat[PP_W-1] = ~pat[PP_W-1];
            rows[i] = {{(ACC_W-PP_W){1'b0}}, pat} << (2*i);
            neg_bits[i] = sel.neg;
        end
    end

    // Place each correction bit at the weight of its row.
    always_comb begin
        corr = '0;
        for (int i = 0; i < NROWS; i++)
            corr[2*i] = neg_bits[i];
    end

endmodule

// File: rtl/csa_reduce.sv
// Carry-save reducer: folds NIN vectors into one sum and one carry vector
// through a chain of 3:2 compressor stages. There is no carry propagation.
// Carries out of the top bit are dropped, which gives wrap-around modulo 2^W.
// Assumes NIN >= 2.
module csa_reduce #(
    parameter int W   = 40,
    parameter int NIN = 13
) (
    input  logic [W-1:0] vin [NIN],
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    logic [W-1:0] s_st [NIN];
    logic [W-1:0] c_st [NIN];

    assign s_st[1] = vin[0];
    assign c_st[1] = vin[1];

    for (genvar k = 2; k < NIN; k++) begin : g_stage
        // One 3:2 compressor layer: add vector k into the running sum/carry pair.
        always_comb begin
            s_st[k] = s_st[k-1] ^ c_st[k-1] ^ vin[k];
            c_st[k] = ((s_st[k-1] & c_st[k-1]) | (s_st[k-1] & vin[k])
                      | (c_st[k-1] & vin[k])) << 1;
        end
    end

    assign s_st[0] = '0;
    assign c_st[0] = '0;
    assign sum_o = s_st[NIN-1];
    assign cry_o = c_st[NIN-1];

endmodule

// File: rtl/booth_csa_mac.sv
// Booth multiply-accumulate unit with the accumulator merged into the
// carry-save reducer. The state is an upper sum vector, an upper carry vector,
// LOW_W resolved low bits and the carry out of the narrow low adder. A full
// total is produced only on request, one cycle after rd_req.
// Assumes ACC_W >= 2*OP_W and 0 < LOW_W < ACC_W.
module booth_csa_mac #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             clr,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             rd_req,
    output logic             res_valid,
    output logic [ACC_W-1:0] res
);
    localparam int NROWS = OP_W / 2;
    localparam int UP_W  = ACC_W - LOW_W;
    localparam int NIN   = NROWS + 5;

    // Constant that cancels the inverted row sign bits: minus the sum of 2^(OP_W+2i).
    function automatic logic [ACC_W-1:0] sign_const();
        logic [ACC_W-1:0] k;
        logic [ACC_W-1:0] one;
        k   = '0;
        one = 1;
        for (int i = 0; i < NROWS; i++)
            k = k - (one << (OP_W + 2*i));
        return k;
    endfunction
    localparam logic [ACC_W-1:0] SIGN_K = sign_const();

    logic [UP_W-1:0]  s_up, c_up;
    logic [LOW_W-1:0] lo_bits;
    logic             lo_cy;

    logic [ACC_W-1:0] pp_rows [NROWS];
    logic [ACC_W-1:0] pp_corr;
    logic [ACC_W-1:0] tree_in [NIN];
    logic [ACC_W-1:0] tree_s, tree_c;
    logic [LOW_W:0]   lo_add;
    logic [UP_W-1:0]  final_up;

    booth_row_gen #(.OP_W(OP_W), .ACC_W(ACC_W)) u_rows (
        .op_a (op_a),
        .op_b (op_b),
        .rows (pp_rows),
        .corr (pp_corr)
    );

    // Assemble reducer inputs: Booth rows, corrections, sign constant, fed-back state (dropped on clear).
    always_comb begin
        for (int i = 0; i < NROWS; i++)
            tree_in[i] = pp_rows[i];
        tree_in[NROWS]   = pp_corr;
        tree_in[NROWS+1] = SIGN_K;
        tree_in[NROWS+2] = clr ? '0 : {s_up, {LOW_W{1'b0}}};
        tree_in[NROWS+3] = clr ? '0 : {c_up, {LOW_W{1'b0}}};
        tree_in[NROWS+4] = clr ? '0 : {{(UP_W-1){1'b0}}, lo_cy, lo_bits};
    end

    csa_reduce #(.W(ACC_W), .NIN(NIN)) u_tree (
        .vin   (tree_in),
        .sum_o (tree_s),
        .cry_o (tree_c)
    );

    // Narrow low-order adder resolves the bottom LOW_W bits every accumulation.
    assign lo_add = {1'b0, tree_s[LOW_W-1:0]} + {1'b0, tree_c[LOW_W-1:0]};

    // Upper carry-propagate adder, used only to form a requested total.
    assign final_up = s_up + c_up + {{(UP_W-1){1'b0}}, lo_cy};

    // Accumulator state update: new product, clear, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || (clr && !acc_en)) begin
            s_up    <= '0;
            c_up    <= '0;
            lo_bits <= '0;
            lo_cy   <= 1'b0;
        end else if (acc_en) begin
            s_up    <= tree_s[ACC_W-1:LOW_W];
            c_up    <= tree_c[ACC_W-1:LOW_W];
            lo_bits <= lo_add[LOW_W-1:0];
            lo_cy   <= lo_add[LOW_W];
        end
    end

    // Result register: capture the pre-update total on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= rd_req;
            if (rd_req)
                res <= {final_up, lo_bits};
        end
    end

    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> res_valid);
    p_valid_only_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !res_valid);
    p_res_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(res));
    p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !acc_en) |=> (s_up == '0 && c_up == '0 && lo_bits == '0 && !lo_cy));
    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc_en) |=> ($stable(s_up) && $stable(c_up) && $stable(lo_bits) && $stable(lo_cy)));

endmodule

// File: tb/booth_csa_mac_bench.sv
// Scoreboard bench: the driver task pushes the expected total on every
// request, and the monitor pops and compares when res_valid appears.
module booth_csa_mac_bench;
    localparam int OP_W  = 16;
    localparam int ACC_W = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_en = 1'b0, clr = 1'b0, rd_req = 1'b0;
    logic [OP_W-1:0]  op_a = '0, op_b = '0;
    logic             res_valid;
    logic [ACC_W-1:0] res;

    int checks = 0;
    int fails  = 0;
    logic [ACC_W-1:0] model = '0;
    logic [ACC_W-1:0] exp_q [$];
    string            tag_q [$];
    logic [ACC_W-1:0] last_res = '0;
    bit               done = 1'b0;

    always #4 clk = ~clk;

    booth_csa_mac u_booth_csa_mac (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .clr(clr),
        .op_a(op_a), .op_b(op_b), .rd_req(rd_req),
        .res_valid(res_valid), .res(res)
    );

    // One cycle of stimulus at the falling edge; the reference model is updated after the request is queued (R3).
    task automatic step(input bit a_en, input bit c, input int a, input int b,
                        input bit req, input string tag);
        logic signed [63:0] prod;
        @(negedge clk);
        acc_en = a_en; clr = c; op_a = a[OP_W-1:0]; op_b = b[OP_W-1:0]; rd_req = req;
        if (req) begin
            exp_q.push_back(model);
            tag_q.push_back(tag);
        end
        if (c) model = '0;
        if (a_en) begin
            prod  = 64'(signed'(a[OP_W-1:0])) * 64'(signed'(b[OP_W-1:0]));
            model = model + prod[ACC_W-1:0];
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 0, 0, 1'b0, "");
    endtask

    // Monitor: compare each valid result with the queue, and check that res holds when not valid (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected res_valid actual=1 expected=0");
                end else begin
                    automatic logic [ACC_W-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (res !== e) begin
                        fails++;
                        $display("FAIL %s res actual=%0d expected=%0d", t,
                                 $signed(res), $signed(e));
                    end
                end
            end else if (res !== last_res) begin
                checks++; fails++;
                $display("FAIL R9 res changed without valid actual=%h expected=%h", res, last_res);
            end
            last_res = res;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        checks++;
        if (res_valid !== 1'b0 || res !== '0) begin
            fails++;
            $display("FAIL R8 reset outputs actual=%b/%h expected=0/0", res_valid, res);
        end
        step(1'b0, 1'b0, 0, 0, 1'b1, "R8");
        idle();
        // R1: simple products, mixed signs
        step(1'b1, 1'b0, 3, 5, 1'b0, "R1");
        step(1'b1, 1'b0, -7, 9, 1'b0, "R1");
        step(1'b1, 1'b0, 123, -456, 1'b0, "R1");
        step(1'b1, 1'b0, -1000, -2000, 1'b0, "R1");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R1");
        idle();
        // R6: operand extremes
        step(1'b1, 1'b1, -32768, -32768, 1'b0, "R6");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R6");
        step(1'b1, 1'b1, -32768, 32767, 1'b0, "R6");
        step(1'b1, 1'b0, 32767, 32767, 1'b1, "R6");
        step(1'b1, 1'b0, -1, -32768, 1'b1, "R6");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R6");
        // R3: request together with accumulate and with clear
        step(1'b1, 1'b0, 11, 13, 1'b1, "R3");
        step(1'b0, 1'b1, 0, 0, 1'b1, "R3");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R4");
        // R4: clear together with a product
        step(1'b1, 1'b0, 500, 600, 1'b0, "R4");
        step(1'b1, 1'b1, -321, 77, 1'b0, "R4");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R4");
        // R5: idle cycles with changing operands must not alter the total
        step(1'b0, 1'b0, 12345, -999, 1'b0, "R5");
        step(1'b0, 1'b0, -32768, -32768, 1'b0, "R5");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R5");
        idle();
        // R7: 1024 products of 2^30 wrap to zero, then one more
        step(1'b0, 1'b1, 0, 0, 1'b0, "R7");
        for (int i = 0; i < 1024; i++)
            step(1'b1, 1'b0, -32768, -32768, 1'b0, "R7");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R7");
        step(1'b1, 1'b0, -32768, 32767, 1'b1, "R7");
        step(1'b0, 1'b0, 0, 0, 1'b1, "R7");
        // R1: pseudo-random sequences with periodic requests
        step(1'b0, 1'b1, 0, 0, 1'b0, "R1");
        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 3) != 0, $urandom_range(0, 40) == 0,
                 int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 65535)) - 32768,
                 (i % 7) == 6, "R1");
        idle();
        idle();
        idle();
        // R2: every request answered exactly once
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2 unanswered requests actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule